// File: doc/BRIEF.md
# Atomic Increment Request Header Generator

This block converts an accepted TCP or UDP packet descriptor into the header of a RoCEv2 Fetch&Add request. The request adds one to a 64-bit counter in remote memory. An upstream address stage supplies four values with each request:

- the destination queue pair,
- the remote key,
- the target virtual address,
- a register index that picks one of the per-queue-pair sequence counters.

The generator keeps one 24-bit packet sequence number (PSN) for each counter slot. Each converted request takes the stored value as its PSN, and the slot is then advanced by one. The headers come out as a byte stream in network byte order, one byte per clock, with start and end markers. The stream holds the Ethernet header, the Global Route Header, the Base Transport Header, the atomic extended header and a zero-filled 4-byte ICRC slot. The original IPv4 and L4 headers are not emitted.

A separate resynchronisation input writes an acknowledged PSN into one slot. Requests for packets that carry neither TCP nor UDP are consumed and produce no output. Addresses and GIDs for both link ends are configuration inputs.

Top module: `atomic_req_hdr_gen`

## Requirements
- R1: A request accepted with `req_is_l4`=1 produces exactly 98 contiguous bytes starting the cycle after acceptance. `out_sop` is set only on the first byte and `out_eop` only on the last.
- R2: Bytes 0..13 hold the destination MAC, the source MAC and then EtherType 0x8915, each most significant byte first.
- R3: Bytes 14..53 hold the GRH. Bytes 14..17 are 60 20 00 00 (version 6, traffic class 2, flow label 0). Payload length is 44 (bytes 18..19). Next header is 27 (byte 20) and hop limit is 1 (byte 21). Source GID is at bytes 22..37 and destination GID at bytes 38..53.
- R4: Bytes 54..65 hold the BTH: opcode 0x14, flag byte 0x40 (only migration request set), partition key FFFF, a zero byte, the 24-bit queue pair (bytes 59..61), a zero byte, and the PSN at bytes 63..65.
- R5: Each slot starts at PSN 0 after reset. A converted request uses the stored value as its PSN, and the slot then holds that value plus one. Slots are independent.
- R6: The PSN wraps from 0xFFFFFF to 0.
- R7: A resync command writes `rs_psn` into the addressed slot. The next request to that slot uses that value.
- R8: If a resync and a converted request address the same slot in the same cycle, the request uses `rs_psn`, and the slot then holds `rs_psn`+1.
- R9: A slot is selected by the low 8 bits of the register index, so indices 0x0103 and 0x0003 share one slot.
- R10: Bytes 66..93 hold the virtual address (8 bytes), the remote key (4 bytes), add data 1 (8 bytes) and a compare field of 0 (8 bytes). Bytes 94..97 are zero.
- R11: A request with `req_is_l4`=0 is consumed without producing output and without changing any PSN.
- R12: `req_ready` is low for every cycle in which a byte is being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_mac | input | 48 | Local MAC address |
| cfg_dst_mac | input | 48 | Collector MAC address |
| cfg_src_gid | input | 128 | Local GID |
| cfg_dst_gid | input | 128 | Collector GID |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Generator idle, request taken when both high |
| req_is_l4 | input | 1 | Packet carried TCP or UDP |
| req_qp | input | 24 | Destination queue pair |
| req_rkey | input | 32 | Remote key |
| req_vaddr | input | 64 | Target virtual address |
| req_reg_idx | input | 16 | PSN slot index (low 8 bits used) |
| rs_valid | input | 1 | Resync command |
| rs_reg_idx | input | 16 | Slot index for resync |
| rs_psn | input | 24 | PSN value to write |
| out_valid | output | 1 | Header byte valid |
| out_sop | output | 1 | First header byte |
| out_eop | output | 1 | Last header byte |
| out_byte | output | 8 | Header byte, network order |

## Verification
The bench targets the PSN corner cases. It drives a wrap from 0xFFFFFF, which a design without modulo arithmetic would turn into a carry into neighbouring bits or a stuck value. It sends a resync and a request to one slot in the same cycle; a design with the wrong priority would emit the old count, or store it plus one. It sends an index above 255, which would open a fresh slot if the upper bits were decoded. It sends a non-TCP/UDP request and then re-reads the slot it touched. A design that filters only the output would have advanced the count, and this shows up in the PSN of the following request. Each header region is compared byte for byte against a separately assembled image, so a swapped field order or a wrong constant flag byte fails.

// File: rtl/fa_hdr_pkg.sv
package fa_hdr_pkg;
  localparam int ETH_BYTES  = 14;
  localparam int GRH_BYTES  = 40;
  localparam int BTH_BYTES  = 12;
  localparam int ATOM_BYTES = 28;
  localparam int ICRC_BYTES = 4;
  localparam int HDR_BYTES  = ETH_BYTES + GRH_BYTES + BTH_BYTES + ATOM_BYTES + ICRC_BYTES;
  localparam int HDR_BITS   = HDR_BYTES * 8;
  localparam int PSN_W      = 24;
  localparam int QP_W       = 24;

  localparam logic [15:0] ETYPE_ROCE   = 16'h8915;
  localparam logic [3:0]  GRH_VER      = 4'd6;
  localparam logic [7:0]  GRH_TCLASS   = 8'd2;
  localparam logic [19:0] GRH_FLOW     = 20'd0;
  localparam logic [15:0] GRH_PAYLEN   = 16'd44;
  localparam logic [7:0]  GRH_NEXTHDR  = 8'd27;
  localparam logic [7:0]  GRH_HOPS     = 8'd1;
  localparam logic [7:0]  BTH_OPC_FADD = 8'h14;
  localparam logic [15:0] BTH_PKEY     = 16'hFFFF;
  localparam logic [63:0] ATOM_ADD     = 64'd1;
  localparam logic [63:0] ATOM_CMP     = 64'd0;

  typedef struct packed {
    logic [47:0]  src_mac;
    logic [47:0]  dst_mac;
    logic [127:0] src_gid;
    logic [127:0] dst_gid;
  } link_cfg_t;

  typedef struct packed {
    logic [QP_W-1:0] qp;
    logic [31:0]     rkey;
    logic [63:0]     vaddr;
  } atom_target_t;

  // Sequence advance, modulo 2^PSN_W by width truncation
  function automatic logic [PSN_W-1:0] psn_next(input logic [PSN_W-1:0] cur);
    return cur + 1'b1;
  endfunction

  // Full header image, byte 0 in the most significant position
  function automatic logic [HDR_BITS-1:0] build_header(input link_cfg_t c,
                                                       input atom_target_t t,
                                                       input logic [PSN_W-1:0] psn);
    logic [ETH_BYTES*8-1:0]  eth;
    logic [GRH_BYTES*8-1:0]  grh;
    logic [BTH_BYTES*8-1:0]  bth;
    logic [ATOM_BYTES*8-1:0] atom;
    logic [ICRC_BYTES*8-1:0] icrc;
    eth  = {c.dst_mac, c.src_mac, ETYPE_ROCE};
    grh  = {GRH_VER, GRH_TCLASS, GRH_FLOW, GRH_PAYLEN, GRH_NEXTHDR, GRH_HOPS,
            c.src_gid, c.dst_gid};
    bth  = {BTH_OPC_FADD, 1'b0, 1'b1, 2'b00, 4'h0, BTH_PKEY,
            8'h00, t.qp, 8'h00, psn};
    atom = {t.vaddr, t.rkey, ATOM_ADD, ATOM_CMP};
    icrc = '0;
    return {eth, grh, bth, atom, icrc};
  endfunction
endpackage

// File: rtl/fa_psn_table.sv
module fa_psn_table
  import fa_hdr_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [AW-1:0]    inc_idx,
  input  logic             rs_en,
  input  logic [AW-1:0]    rs_idx,
  input  logic [PSN_W-1:0] rs_val,
  output logic [PSN_W-1:0] psn_out
);
  logic [PSN_W-1:0] slot_q [ENTRIES];
  logic             clash;

  assign clash   = inc_en && rs_en && (inc_idx == rs_idx);
  assign psn_out = clash ? rs_val : slot_q[inc_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) slot_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (inc_en && inc_idx == AW'(e))
          slot_q[e] <= psn_next(psn_out);
        else if (rs_en && rs_idx == AW'(e))
          slot_q[e] <= rs_val;
      end
    end
  end
endmodule

// File: rtl/fa_hdr_shifter.sv
module fa_hdr_shifter
  import fa_hdr_pkg::*;
#(
  localparam int CW   = $clog2(HDR_BYTES),
  localparam int LAST = HDR_BYTES - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [HDR_BITS-1:0] load_hdr,
  output logic                busy,
  output logic                sop,
  output logic                eop,
  output logic [7:0]          byte_o
);
  logic [HDR_BITS-1:0] img_q;
  logic [CW-1:0]       cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      img_q <= '0;
    end else if (load && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      img_q <= load_hdr;
    end else if (busy) begin
      img_q <= img_q << 8;
      if (cnt_q == CW'(LAST)) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign byte_o = img_q[HDR_BITS-1 -: 8];
  assign sop    = busy && (cnt_q == '0);
  assign eop    = busy && (cnt_q == CW'(LAST));
endmodule

// File: rtl/atomic_req_hdr_gen.sv
module atomic_req_hdr_gen
  import fa_hdr_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [47:0]      cfg_src_mac,
  input  logic [47:0]      cfg_dst_mac,
  input  logic [127:0]     cfg_src_gid,
  input  logic [127:0]     cfg_dst_gid,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_l4,
  input  logic [QP_W-1:0]  req_qp,
  input  logic [31:0]      req_rkey,
  input  logic [63:0]      req_vaddr,
  input  logic [IDX_W-1:0] req_reg_idx,
  input  logic             rs_valid,
  input  logic [IDX_W-1:0] rs_reg_idx,
  input  logic [PSN_W-1:0] rs_psn,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic [7:0]       out_byte
);
  // Named internal events
  logic             take_any;
  logic             take_l4;
  logic [PSN_W-1:0] psn_grant;
  logic             busy;
  link_cfg_t        cfg;
  atom_target_t     tgt;
  logic [HDR_BITS-1:0] next_hdr;

  assign req_ready = !busy;
  assign take_any  = req_valid && req_ready;
  assign take_l4   = take_any && req_is_l4;

  assign cfg = '{src_mac: cfg_src_mac, dst_mac: cfg_dst_mac,
                 src_gid: cfg_src_gid, dst_gid: cfg_dst_gid};
  assign tgt = '{qp: req_qp, rkey: req_rkey, vaddr: req_vaddr};

  fa_psn_table #(.ENTRIES(ENTRIES)) u_psn (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (take_l4),
    .inc_idx (req_reg_idx[AW-1:0]),
    .rs_en   (rs_valid),
    .rs_idx  (rs_reg_idx[AW-1:0]),
    .rs_val  (rs_psn),
    .psn_out (psn_grant)
  );

  assign next_hdr = build_header(cfg, tgt, psn_grant);

  fa_hdr_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_l4),
    .load_hdr (next_hdr),
    .busy     (busy),
    .sop      (out_sop),
    .eop      (out_eop),
    .byte_o   (out_byte)
  );

  assign out_valid = busy;
endmodule

// File: rtl/fa_hdr_checker.sv
module fa_hdr_checker
  import fa_hdr_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 16,
  localparam int AW     = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_is_l4,
  input logic [IDX_W-1:0] req_reg_idx,
  input logic             rs_valid,
  input logic [IDX_W-1:0] rs_reg_idx,
  input logic [PSN_W-1:0] rs_psn,
  input logic             take_l4,
  input logic [PSN_W-1:0] psn_grant,
  input logic             out_valid,
  input logic             out_sop,
  input logic             out_eop
);
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    take_l4 |=> (out_valid && out_sop)); // R1
  AST_SOP_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sop); // R1
  AST_EOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> !out_valid); // R1
  AST_MARKERS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sop || out_eop) |-> out_valid); // R1
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready); // R12
  AST_NONL4_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_is_l4) |=> !out_valid); // R11
  AST_RESYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_l4 && rs_valid && rs_reg_idx[AW-1:0] == req_reg_idx[AW-1:0])
      |-> (psn_grant == rs_psn)); // R8
endmodule

bind atomic_req_hdr_gen fa_hdr_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_is_l4   (req_is_l4),
  .req_reg_idx (req_reg_idx),
  .rs_valid    (rs_valid),
  .rs_reg_idx  (rs_reg_idx),
  .rs_psn      (rs_psn),
  .take_l4     (take_l4),
  .psn_grant   (psn_grant),
  .out_valid   (out_valid),
  .out_sop     (out_sop),
  .out_eop     (out_eop)
);

// File: tb/atomic_req_hdr_gen_tb_top.sv
module atomic_req_hdr_gen_tb_top;
  localparam int NB = 98;
  localparam logic [47:0]  SMAC = 48'h02_11_22_33_44_55;
  localparam logic [47:0]  DMAC = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [127:0] SGID = 128'hFE80_0000_0000_0000_0011_22FF_FE33_4455;
  localparam logic [127:0] DGID = 128'hFE80_0000_0000_0000_00AA_BBFF_FECC_DDEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_is_l4 = 1'b0, rs_valid = 1'b0;
  logic [23:0] req_qp = '0, rs_psn = '0;
  logic [31:0] req_rkey = '0;
  logic [63:0] req_vaddr = '0;
  logic [15:0] req_reg_idx = '0, rs_reg_idx = '0;
  logic req_ready, out_valid, out_sop, out_eop;
  logic [7:0] out_byte;

  int checks = 0;
  int failures = 0;
  logic [7:0] rx [NB];
  logic [7:0] ex [NB];

  always #4 clk = ~clk;

  atomic_req_hdr_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_mac(SMAC), .cfg_dst_mac(DMAC), .cfg_src_gid(SGID), .cfg_dst_gid(DGID),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_l4(req_is_l4),
    .req_qp(req_qp), .req_rkey(req_rkey), .req_vaddr(req_vaddr), .req_reg_idx(req_reg_idx),
    .rs_valid(rs_valid), .rs_reg_idx(rs_reg_idx), .rs_psn(rs_psn),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_byte(out_byte)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(inout int p, input logic [127:0] v, input int n);
    for (int k = 0; k < n; k++) ex[p + k] = v[8*(n-1-k) +: 8];
    p += n;
  endtask

  task automatic make_expected(input logic [23:0] qp, input logic [31:0] rk,
                               input logic [63:0] va, input logic [23:0] psn);
    int p = 0;
    put(p, DMAC, 6); put(p, SMAC, 6); put(p, 16'h8915, 2);
    put(p, 32'h6020_0000, 4); put(p, 16'd44, 2); put(p, 8'd27, 1); put(p, 8'd1, 1);
    put(p, SGID, 16); put(p, DGID, 16);
    put(p, 8'h14, 1); put(p, 8'h40, 1); put(p, 16'hFFFF, 2); put(p, 8'h00, 1);
    put(p, qp, 3); put(p, 8'h00, 1); put(p, psn, 3);
    put(p, va, 8); put(p, rk, 4); put(p, 64'd1, 8); put(p, 64'd0, 8);
    put(p, 32'd0, 4);
  endtask

  task automatic region(input string req, input int lo, input int hi);
    int bad = -1;
    for (int i = lo; i <= hi; i++) if (bad < 0 && rx[i] !== ex[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, $sformatf("%s byte %0d", req, bad), 64'(rx[bad]), 64'(ex[bad]));
  endtask

  // Drive one request (optionally with a simultaneous resync); collect the header when converted
  task automatic issue(input bit l4, input logic [23:0] qp, input logic [31:0] rk,
                       input logic [63:0] va, input logic [15:0] idx,
                       input bit rs, input logic [15:0] ridx, input logic [23:0] rval,
                       output logic [23:0] psn_seen);
    bit frame_ok = 1'b1, ready_ok = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_is_l4 = l4; req_qp = qp; req_rkey = rk; req_vaddr = va;
    req_reg_idx = idx; rs_valid = rs; rs_reg_idx = ridx; rs_psn = rval;
    @(negedge clk);
    req_valid = 1'b0; rs_valid = 1'b0;
    psn_seen = 'x;
    if (!l4) return;
    for (int i = 0; i < NB; i++) begin
      if (!out_valid || out_sop !== (i == 0) || out_eop !== (i == NB - 1)) frame_ok = 1'b0;
      if (req_ready) ready_ok = 1'b0;
      rx[i] = out_byte;
      @(negedge clk);
    end
    chk(frame_ok && !out_valid, "R1 framing", 64'(out_valid), 0);
    chk(ready_ok, "R12 ready low while emitting", 0, 1);
    psn_seen = {rx[63], rx[64], rx[65]};
  endtask

  task automatic full_compare(input logic [23:0] qp, input logic [31:0] rk,
                              input logic [63:0] va, input logic [23:0] psn);
    make_expected(qp, rk, va, psn);
    region("R2 ethernet", 0, 13);
    region("R3 grh", 14, 53);
    region("R4 bth", 54, 65);
    region("R10 atomic", 66, 93);
    region("R10 icrc", 94, 97);
  endtask

  task automatic resync_only(input logic [15:0] idx, input logic [23:0] v);
    @(negedge clk);
    rs_valid = 1'b1; rs_reg_idx = idx; rs_psn = v;
    @(negedge clk);
    rs_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!out_valid && req_ready, "R1 reset idle", 64'({out_valid, req_ready}), 64'b01);
  endtask

  task automatic t_first_and_increment();
    logic [23:0] p;
    issue(1, 24'h000123, 32'hCAFE0001, 64'h0000_7F00_1000_0040, 16'h0003, 0, 0, 0, p);
    chk(p == 24'd0, "R5 first psn", 64'(p), 0);
    full_compare(24'h000123, 32'hCAFE0001, 64'h0000_7F00_1000_0040, 24'd0);
    issue(1, 24'hABCDEF, 32'h1234_5678, 64'hFFEE_DDCC_BBAA_9988, 16'h0003, 0, 0, 0, p);
    chk(p == 24'd1, "R5 post increment", 64'(p), 1);
    full_compare(24'hABCDEF, 32'h1234_5678, 64'hFFEE_DDCC_BBAA_9988, 24'd1);
    issue(1, 24'h000004, 32'h0, 64'h8, 16'h0004, 0, 0, 0, p);
    chk(p == 24'd0, "R5 independent slot", 64'(p), 0);
  endtask

  task automatic t_non_l4();
    logic [23:0] p;
    bit quiet = 1'b1;
    issue(0, 24'h1, 32'h1, 64'h1, 16'h0003, 0, 0, 0, p);
    for (int i = 0; i < 6; i++) begin
      if (out_valid || !req_ready) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R11 no output for non-l4", 64'(out_valid), 0);
    issue(1, 24'h1, 32'h1, 64'h1, 16'h0003, 0, 0, 0, p);
    chk(p == 24'd2, "R11 psn untouched by non-l4", 64'(p), 2);
  endtask

  task automatic t_alias();
    logic [23:0] p;
    issue(1, 24'h7, 32'h7, 64'h7, 16'h0103, 0, 0, 0, p);
    chk(p == 24'd3, "R9 low index bits select slot", 64'(p), 3);
  endtask

  task automatic t_resync();
    logic [23:0] p;
    resync_only(16'h0007, 24'h00ABCD);
    issue(1, 24'h9, 32'h9, 64'h9, 16'h0007, 0, 0, 0, p);
    chk(p == 24'h00ABCD, "R7 resync value used", 64'(p), 64'h00ABCD);
    issue(1, 24'h9, 32'h9, 64'h9, 16'h0007, 0, 0, 0, p);
    chk(p == 24'h00ABCE, "R7 increments after resync", 64'(p), 64'h00ABCE);
  endtask

  task automatic t_same_cycle();
    logic [23:0] p;
    issue(1, 24'h2, 32'h2, 64'h2, 16'h0020, 1, 16'h0020, 24'h123456, p);
    chk(p == 24'h123456, "R8 resync wins same cycle", 64'(p), 64'h123456);
    issue(1, 24'h2, 32'h2, 64'h2, 16'h0020, 1, 16'h0021, 24'h000500, p);
    chk(p == 24'h123457, "R8 stored resync plus one", 64'(p), 64'h123457);
    issue(1, 24'h2, 32'h2, 64'h2, 16'h0021, 0, 0, 0, p);
    chk(p == 24'h000500, "R7 other-slot resync in parallel", 64'(p), 64'h000500);
  endtask

  task automatic t_wrap();
    logic [23:0] p;
    resync_only(16'h00FF, 24'hFFFFFF);
    issue(1, 24'h5, 32'h5, 64'h5, 16'h00FF, 0, 0, 0, p);
    chk(p == 24'hFFFFFF, "R6 top value", 64'(p), 64'hFFFFFF);
    issue(1, 24'h5, 32'h5, 64'h5, 16'h00FF, 0, 0, 0, p);
    chk(p == 24'h000000, "R6 wrap to zero", 64'(p), 0);
    full_compare(24'h5, 32'h5, 64'h5, 24'h0);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_and_increment();
    t_non_l4();
    t_alias();
    t_resync();
    t_same_cycle();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule